// File: doc/BRIEF.md
# Reset Strap Configuration Latch

This block decodes a set of hardware configuration options from pins that have another use once the device runs. While reset is held, the board pulls selected pins low to choose options. The block samples them when reset is released and then holds the decoded controls constant until the next reset. The pins are active-low: a pin driven low during reset selects its option. The controls are an output tri-state enable, a self-test request, two flags that turn off error-signal observation, and a two-bit agent number for symmetric arbitration.

Reset comes from two sources: the reset pin and the power-good indication. Either one going low resets the block. A warm reset (power-good stays high) and a cold reset (power-good low) give exactly the same configuration. Both the strap pins and the reset release pass through two-flop synchronizers. The capture register loads on the single cycle in which the synchronized reset deasserts. Address pins that are not straps must stay high during reset. If any of them is low at the sampling point, a sticky illegal-strap flag is set, and only the next reset clears it.

Top module: `strap_cfg_latch`

## Requirements
- R1: The decoded outputs take the strap values on the third rising clock edge after both the reset pin and power-good are high. The values present on the pins at the first of those edges are the ones used.
- R2: Once captured, the outputs stay constant whatever the strap pins do, until the next reset.
- R3: A reset with power-good held high yields the same outputs as a reset with power-good low, for the same straps.
- R4: `cfg_tristate` is 1 exactly when `smi_strap_n` was low at capture.
- R5: `cfg_selftest` is 1 exactly when address pin 3 (`addr_n[3]`) was low at capture.
- R6: `cfg_no_mchk_obs` is 1 exactly when `addr_n[9]` was low, and `cfg_no_binit_obs` is 1 exactly when `addr_n[10]` was low, at capture.
- R7: `cfg_agent_id[i]` equals the inverse of `breq_n[i]` at capture, for i = 0 and 1.
- R8: `cfg_illegal` is 1 when any address pin other than bits 3, 9 and 10 was low at capture. It stays set until the next reset, and a reset with legal straps leaves it 0.
- R9: All outputs are 0 while reset is asserted and until the capture edge of R1.
- R10: Power-good going low on its own, with the reset pin high, clears all outputs at once (asynchronous reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_pin_n | input | 1 | Reset pin, active low, asynchronous assert |
| pwr_good | input | 1 | Power-good indication, low forces reset |
| smi_strap_n | input | 1 | Tri-state select strap, active low |
| breq_n | input | 2 | Agent number straps, active low |
| addr_n | input | ADDR_W (16) | Address pins used as straps, active low |
| cfg_tristate | output | 1 | Output tri-state mode selected |
| cfg_selftest | output | 1 | Self-test requested |
| cfg_no_mchk_obs | output | 1 | Machine-check error observation disabled |
| cfg_no_binit_obs | output | 1 | Bus-init observation disabled |
| cfg_agent_id | output | 2 | Symmetric arbitration agent number |
| cfg_illegal | output | 1 | Sticky flag: a non-strap address pin was low at capture |

## Verification
The decoded outputs are due on the third rising edge after the release of reset: two edges pass through the reset synchronizer and one loads the capture register. The bench therefore checks after the second edge that the outputs are still 0, and after the third edge that they hold the expected values. It samples 1 ns after each edge and drives all inputs on falling edges. Power-good loss clears the outputs with no clock edge, and the bench checks this a few nanoseconds after the drop. The freeze is checked five edges after the straps are inverted, which gives the synchronizer enough time to carry the new values.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

  localparam int unsigned AID_W      = 2;
  localparam int unsigned MAX_ADDR_W = 64;

  typedef logic [MAX_ADDR_W-1:0] addr_vec_t;

  typedef struct packed {
    logic             tristate;
    logic             selftest;
    logic             no_mchk_obs;
    logic             no_binit_obs;
    logic [AID_W-1:0] agent_id;
    logic             illegal;
  } cfg_t;

  localparam cfg_t CFG_IDLE = '0;

  // Mask of the address pins that physically exist.
  function automatic addr_vec_t present_mask(int unsigned width);
    addr_vec_t m;
    m = '0;
    for (int unsigned i = 0; i < MAX_ADDR_W; i++) begin
      if (i < width) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Mask of the address pins that are allowed to be low during reset.
  function automatic addr_vec_t allow_mask(int unsigned i_a, int unsigned i_b,
                                           int unsigned i_c);
    addr_vec_t m;
    m = '0;
    m[i_a] = 1'b1;
    m[i_b] = 1'b1;
    m[i_c] = 1'b1;
    return m;
  endfunction

  // Any existing, non-strap pin driven low.
  function automatic logic strap_violation(addr_vec_t addr_n, addr_vec_t allow,
                                           addr_vec_t present);
    return |(~addr_n & ~allow & present);
  endfunction

  // Full decode of one strap sample into configuration controls.
  function automatic cfg_t strap_decode(logic smi_n, logic [AID_W-1:0] breq_n,
                                        addr_vec_t addr_n, addr_vec_t present,
                                        int unsigned i_bist, int unsigned i_mchk,
                                        int unsigned i_binit);
    cfg_t c;
    c.tristate     = ~smi_n;
    c.selftest     = ~addr_n[i_bist];
    c.no_mchk_obs  = ~addr_n[i_mchk];
    c.no_binit_obs = ~addr_n[i_binit];
    c.agent_id     = ~breq_n;
    c.illegal      = strap_violation(addr_n, allow_mask(i_bist, i_mchk, i_binit),
                                     present);
    return c;
  endfunction

endpackage

// File: rtl/strap_rst_sync.sv
// Reset synchronizer: asynchronous assert, STAGES-flop synchronous release,
// plus one extra flop to mark the single release cycle.
module strap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n,
  output logic release_pulse
);

  logic [STAGES-1:0] chain_q;
  logic              seen_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) seen_q <= 1'b0;
    else         seen_q <= chain_q[STAGES-1];
  end

  assign rst_sync_n    = chain_q[STAGES-1];
  assign release_pulse = chain_q[STAGES-1] & ~seen_q;

endmodule

// File: rtl/strap_pin_sync.sv
// Per-bit multi-flop synchronizer for strap pins; runs during reset so the
// pins are already settled when the release arrives.
module strap_pin_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] pins,
  output logic [W-1:0] pins_sync
);

  logic [STAGES-1:0][W-1:0] pipe_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) pipe_q[0] <= pins;
    end else begin : g_next
      always_ff @(posedge clk) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign pins_sync = pipe_q[STAGES-1];

endmodule

// File: rtl/strap_capture.sv
// Capture register: cleared by reset, loaded once on the release cycle.
module strap_capture
  import strap_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned IDX_BIST     = 3,
  parameter int unsigned IDX_NO_MCHK  = 9,
  parameter int unsigned IDX_NO_BINIT = 10
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              load,
  input  logic              smi_n,
  input  logic [AID_W-1:0]  breq_n,
  input  logic [ADDR_W-1:0] addr_n,
  output cfg_t              cfg_next,
  output cfg_t              cfg_q
);

  localparam addr_vec_t PRESENT = present_mask(ADDR_W);

  addr_vec_t addr_ext;
  assign addr_ext = MAX_ADDR_W'(addr_n);

  always_comb begin
    cfg_next = strap_decode(smi_n, breq_n, addr_ext, PRESENT,
                            IDX_BIST, IDX_NO_MCHK, IDX_NO_BINIT);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)   cfg_q <= CFG_IDLE;
    else if (load) cfg_q <= cfg_next;
  end

endmodule

// File: rtl/strap_cfg_latch.sv
module strap_cfg_latch
  import strap_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned IDX_BIST     = 3,
  parameter int unsigned IDX_NO_MCHK  = 9,
  parameter int unsigned IDX_NO_BINIT = 10,
  parameter int unsigned RST_STAGES   = 2,
  parameter int unsigned PIN_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_pin_n,
  input  logic              pwr_good,
  input  logic              smi_strap_n,
  input  logic [AID_W-1:0]  breq_n,
  input  logic [ADDR_W-1:0] addr_n,
  output logic              cfg_tristate,
  output logic              cfg_selftest,
  output logic              cfg_no_mchk_obs,
  output logic              cfg_no_binit_obs,
  output logic [AID_W-1:0]  cfg_agent_id,
  output logic              cfg_illegal
);

  localparam int unsigned STRAP_W = ADDR_W + AID_W + 1;

  // Either source forces reset; warm and cold resets are not told apart.
  logic arst_n;
  assign arst_n = rst_pin_n & pwr_good;

  logic rst_sync_n;
  logic release_pulse;

  strap_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk           (clk),
    .arst_n        (arst_n),
    .rst_sync_n    (rst_sync_n),
    .release_pulse (release_pulse)
  );

  logic [STRAP_W-1:0] strap_raw;
  logic [STRAP_W-1:0] strap_sync;
  assign strap_raw = {smi_strap_n, breq_n, addr_n};

  strap_pin_sync #(.W(STRAP_W), .STAGES(PIN_STAGES)) u_pin_sync (
    .clk       (clk),
    .pins      (strap_raw),
    .pins_sync (strap_sync)
  );

  logic              sync_smi_n;
  logic [AID_W-1:0]  sync_breq_n;
  logic [ADDR_W-1:0] sync_addr_n;
  assign {sync_smi_n, sync_breq_n, sync_addr_n} = strap_sync;

  cfg_t cfg_next;
  cfg_t cfg_q;

  strap_capture #(
    .ADDR_W       (ADDR_W),
    .IDX_BIST     (IDX_BIST),
    .IDX_NO_MCHK  (IDX_NO_MCHK),
    .IDX_NO_BINIT (IDX_NO_BINIT)
  ) u_capture (
    .clk      (clk),
    .arst_n   (arst_n),
    .load     (release_pulse),
    .smi_n    (sync_smi_n),
    .breq_n   (sync_breq_n),
    .addr_n   (sync_addr_n),
    .cfg_next (cfg_next),
    .cfg_q    (cfg_q)
  );

  assign cfg_tristate     = cfg_q.tristate;
  assign cfg_selftest     = cfg_q.selftest;
  assign cfg_no_mchk_obs  = cfg_q.no_mchk_obs;
  assign cfg_no_binit_obs = cfg_q.no_binit_obs;
  assign cfg_agent_id     = cfg_q.agent_id;
  assign cfg_illegal      = cfg_q.illegal;

endmodule

// File: rtl/strap_cfg_chk.sv
module strap_cfg_chk #(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned IDX_BIST     = 3,
  parameter int unsigned IDX_NO_MCHK  = 9,
  parameter int unsigned IDX_NO_BINIT = 10
) (
  input logic              clk,
  input logic              arst_n,
  input logic              rst_sync_n,
  input logic              release_pulse,
  input logic              sync_smi_n,
  input logic [1:0]        sync_breq_n,
  input logic [ADDR_W-1:0] sync_addr_n,
  input logic              cfg_tristate,
  input logic              cfg_selftest,
  input logic              cfg_no_mchk_obs,
  input logic              cfg_no_binit_obs,
  input logic [1:0]        cfg_agent_id,
  input logic              cfg_illegal
);

  logic [7:0] outs;
  assign outs = {cfg_tristate, cfg_selftest, cfg_no_mchk_obs, cfg_no_binit_obs,
                 cfg_agent_id, cfg_illegal, 1'b0};

  logic [ADDR_W-1:0] non_strap;
  always_comb begin
    non_strap = ~sync_addr_n;
    non_strap[IDX_BIST]     = 1'b0;
    non_strap[IDX_NO_MCHK]  = 1'b0;
    non_strap[IDX_NO_BINIT] = 1'b0;
  end

  p_single_release_r1: assert property (@(posedge clk) disable iff (!arst_n)
    release_pulse |=> !release_pulse);

  p_frozen_r2: assert property (@(posedge clk) disable iff (!arst_n)
    !release_pulse |=> $stable(outs));

  p_tristate_r4: assert property (@(posedge clk) disable iff (!arst_n)
    release_pulse |=> cfg_tristate == !$past(sync_smi_n));

  p_selftest_r5: assert property (@(posedge clk) disable iff (!arst_n)
    release_pulse |=> cfg_selftest == !$past(sync_addr_n[IDX_BIST]));

  p_obs_r6: assert property (@(posedge clk) disable iff (!arst_n)
    release_pulse |=> (cfg_no_mchk_obs == !$past(sync_addr_n[IDX_NO_MCHK])) &&
                      (cfg_no_binit_obs == !$past(sync_addr_n[IDX_NO_BINIT])));

  p_agent_r7: assert property (@(posedge clk) disable iff (!arst_n)
    release_pulse |=> cfg_agent_id == ~$past(sync_breq_n));

  p_illegal_r8: assert property (@(posedge clk) disable iff (!arst_n)
    release_pulse |=> cfg_illegal == $past(|non_strap));

  p_idle_r9: assert property (@(posedge clk) disable iff (!arst_n)
    !rst_sync_n |-> outs == 8'h00);

endmodule

bind strap_cfg_latch strap_cfg_chk #(
  .ADDR_W       (ADDR_W),
  .IDX_BIST     (IDX_BIST),
  .IDX_NO_MCHK  (IDX_NO_MCHK),
  .IDX_NO_BINIT (IDX_NO_BINIT)
) u_chk (
  .clk              (clk),
  .arst_n           (arst_n),
  .rst_sync_n       (rst_sync_n),
  .release_pulse    (release_pulse),
  .sync_smi_n       (sync_smi_n),
  .sync_breq_n      (sync_breq_n),
  .sync_addr_n      (sync_addr_n),
  .cfg_tristate     (cfg_tristate),
  .cfg_selftest     (cfg_selftest),
  .cfg_no_mchk_obs  (cfg_no_mchk_obs),
  .cfg_no_binit_obs (cfg_no_binit_obs),
  .cfg_agent_id     (cfg_agent_id),
  .cfg_illegal      (cfg_illegal)
);

// File: tb/strap_cfg_latch_tb.sv
`timescale 1ns/1ps
module strap_cfg_latch_tb;

  logic        clk = 1'b0;
  logic        rst_pin_n = 1'b0;
  logic        pwr_good = 1'b0;
  logic        smi_strap_n = 1'b1;
  logic [1:0]  breq_n = 2'b11;
  logic [15:0] addr_n = 16'hFFFF;
  logic        cfg_tristate, cfg_selftest, cfg_no_mchk_obs, cfg_no_binit_obs;
  logic [1:0]  cfg_agent_id;
  logic        cfg_illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  strap_cfg_latch u_dut (
    .clk(clk), .rst_pin_n(rst_pin_n), .pwr_good(pwr_good),
    .smi_strap_n(smi_strap_n), .breq_n(breq_n), .addr_n(addr_n),
    .cfg_tristate(cfg_tristate), .cfg_selftest(cfg_selftest),
    .cfg_no_mchk_obs(cfg_no_mchk_obs), .cfg_no_binit_obs(cfg_no_binit_obs),
    .cfg_agent_id(cfg_agent_id), .cfg_illegal(cfg_illegal)
  );

  // Vector layout: {smi_n, breq_n[1:0], addr_n[15:0]}
  localparam int NV = 8;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 2'b11, 16'hFFFF},   // nothing selected
    {1'b0, 2'b11, 16'hFFFF},   // R4 tri-state
    {1'b1, 2'b11, 16'hFFF7},   // R5 self-test (bit 3)
    {1'b1, 2'b11, 16'hF9FF},   // R6 bits 9 and 10
    {1'b1, 2'b01, 16'hFFFF},   // R7 id = 2'b10
    {1'b1, 2'b10, 16'hFFF7},   // R7 id = 2'b01 plus R5
    {1'b1, 2'b11, 16'hFFFE},   // R8 bit 0 illegal
    {1'b0, 2'b00, 16'h79F7}    // all options plus bit 15 illegal (R8)
  };

  function automatic string vec_tag(int i);
    case (i)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R7 R5";
      6: return "R8";
      7: return "R8 R4 R6";
      default: return "R1";
    endcase
  endfunction

  // Expected {tristate, selftest, no_mchk, no_binit, id[1:0], illegal}
  function automatic logic [6:0] expect_of(logic [18:0] v);
    logic [15:0] low;
    logic        bad;
    low = ~v[15:0];
    bad = 1'b0;
    for (int b = 0; b < 16; b++)
      if (low[b] && b != 3 && b != 9 && b != 10) bad = 1'b1;
    return {~v[18], low[3], low[9], low[10], ~v[17:16], bad};
  endfunction

  function automatic logic [6:0] outs();
    return {cfg_tristate, cfg_selftest, cfg_no_mchk_obs, cfg_no_binit_obs,
            cfg_agent_id, cfg_illegal};
  endfunction

  task automatic check(string tag, logic [6:0] got, logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic drive(logic [18:0] v);
    {smi_strap_n, breq_n, addr_n} = v;
  endtask

  // Reset (warm or cold) with straps v, release, check timing and value.
  task automatic run_vec(logic [18:0] v, bit warm, string tag);
    @(negedge clk);
    drive(v);
    rst_pin_n = 1'b0;
    pwr_good  = warm;
    repeat (4) @(negedge clk);
    check({"R9 in reset ", tag}, outs(), 7'b0);
    rst_pin_n = 1'b1;
    pwr_good  = 1'b1;
    repeat (2) @(posedge clk);
    #1 check({"R9 before capture ", tag}, outs(), 7'b0);
    @(posedge clk);
    #1 check({warm ? "R1 warm " : "R1 R3 cold ", tag}, outs(), expect_of(v));
    @(negedge clk);
    drive(~v);
    repeat (5) @(posedge clk);
    #1 check({"R2 frozen ", tag}, outs(), expect_of(v));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R9 power-on", outs(), 7'b0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i[0], vec_tag(i));

    // R3: same straps, warm then cold, identical result.
    run_vec(VEC[7], 1'b1, "R3 warm pair");
    run_vec(VEC[7], 1'b0, "R3 cold pair");

    // R8: illegal flag held, then cleared by a reset with legal straps.
    run_vec(VEC[6], 1'b1, "R8 set");
    repeat (10) @(posedge clk);
    #1 check("R8 sticky", {6'b0, cfg_illegal}, 7'd1);
    run_vec(VEC[3], 1'b1, "R8 cleared");

    // R10: power-good drop alone clears outputs immediately.
    run_vec(VEC[7], 1'b1, "R10 setup");
    @(negedge clk);
    pwr_good = 1'b0;
    #2 check("R10 power-good drop", outs(), 7'b0);
    @(negedge clk);
    pwr_good = 1'b1;
    repeat (2) @(posedge clk);
    #1 check("R10 R9 still idle", outs(), 7'b0);
    drive(VEC[1]);
    repeat (5) @(posedge clk);

    // R1: straps present at the first edge after release are the ones used.
    @(negedge clk);
    drive(VEC[2]);
    rst_pin_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_pin_n = 1'b1;
    @(posedge clk);
    #1;
    @(negedge clk);
    drive(VEC[0]);
    repeat (2) @(posedge clk);
    #1 check("R1 sample point", outs(), expect_of(VEC[2]));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule